// File: doc/BRIEF.md
# Virtualization Intercept Check Dispatcher

This block decides, one event at a time, whether something a guest did must force an exit to the host. Each event arrives as a 32-bit type code plus a 64-bit parameter. The block range-decodes the code into one of five narrow intercept masks (control-register read, control-register write, debug-register read, debug-register write, exception) or into one wide 64-bit general vector. It picks the mask bit at the code's offset from that range's base. A set bit produces a one-cycle exit request that carries the type and the parameter. An event that is not intercepted produces a one-cycle done pulse instead.

The masks are loaded by a single arm strobe. The same strobe sets the intercept-enable flag that gates every check. An exit request clears all masks and drops the flag.

Two codes, the MSR access code and the port I/O code, also need a permission-table lookup. These codes first test their general-vector bit. If that bit is set, the block raises a request to an external lookup block and stays busy until a hit or miss response returns.

Top module: `vix_intercept_top`

## Requirements
- R1: While the enable flag (`en_o`) is low, an accepted event of any type gives `done_o`=1 and `exit_valid_o`=0 in the cycle after acceptance.
- R2: Codes CR_RD_BASE to CR_RD_BASE+8 (9 codes) test bit (code - CR_RD_BASE) of the 16-bit CR-read mask. Code CR_RD_BASE+9 is not in this range.
- R3: Codes CR_WR_BASE to CR_WR_BASE+8 test bit (code - CR_WR_BASE) of the 16-bit CR-write mask.
- R4: Codes DR_RD_BASE+0..7 and DR_WR_BASE+0..7 test bit (code - base) of their own 16-bit masks. Offset 8 is outside either range.
- R5: Codes EXC_BASE to EXC_BASE+31 test bit (code - EXC_BASE) of the 32-bit exception mask.
- R6: Any other code in GEN_BASE to GEN_BASE+63 tests bit (code - GEN_BASE) of the 64-bit general vector. A code in no range is never intercepted.
- R7: For MSR_CODE and IO_CODE, a clear general-vector bit gives `done_o` with no lookup. A set bit raises `lk_req_o` (with `lk_io_o`=1 for IO_CODE) and `busy_o` from the next cycle on.
- R8: While a lookup waits, `lk_rsp_i` with `lk_hit_i`=1 gives an exit request in the next cycle, and `lk_hit_i`=0 gives `done_o`.
- R9: An exit request is `exit_valid_o` high for one cycle, with `exit_type_o`/`exit_param_o` equal to the accepted event's type and parameter.
- R10: An exit request clears the enable flag and all masks, so a repeat of the same event then only gives `done_o`.
- R11: `arm_i` loads all six masks and sets `en_o` at the next edge.
- R12: An event offered while busy is ignored: no exit, no done, and the pending lookup payload is unchanged.
- R13: When `arm_i` coincides with an intercepted event, the event is judged with the old masks, the exit is issued, and the newly armed masks and the enable flag survive.
- R14: After reset, `en_o`, `busy_o`, `lk_req_o`, `exit_valid_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Load masks and set enable flag |
| cr_rd_mask_i | input | 16 | CR-read intercept mask to load |
| cr_wr_mask_i | input | 16 | CR-write intercept mask to load |
| dr_rd_mask_i | input | 16 | DR-read intercept mask to load |
| dr_wr_mask_i | input | 16 | DR-write intercept mask to load |
| exc_mask_i | input | 32 | Exception intercept mask to load |
| gen_mask_i | input | 64 | General intercept vector to load |
| en_o | output | 1 | Intercept-enable flag |
| ev_valid_i | input | 1 | Event offered |
| ev_type_i | input | 32 | Event type code |
| ev_param_i | input | 64 | Event parameter |
| busy_o | output | 1 | Waiting for a lookup response |
| lk_req_o | output | 1 | Permission lookup request (level) |
| lk_io_o | output | 1 | Lookup is for port I/O (0: MSR) |
| lk_type_o | output | 32 | Type of the pending lookup |
| lk_param_o | output | 64 | Parameter of the pending lookup |
| lk_rsp_i | input | 1 | Lookup response valid |
| lk_hit_i | input | 1 | Lookup response: access intercepted |
| exit_valid_o | output | 1 | Exit request strobe |
| exit_type_o | output | 32 | Exit request type |
| exit_param_o | output | 64 | Exit request parameter |
| done_o | output | 1 | Event finished without exit |

## Verification
Two operations can land on the same edge. The first is an exit, which wants to clear the masks and the enable flag. The second is an arm strobe, which wants to load them. The bench drives `arm_i` together with an event that the current exception mask intercepts. It then checks three things: the exit is issued from the old masks, `en_o` stays high, and a follow-up event is judged by the freshly loaded CR-read mask. A second overlap, an event arriving while a lookup is pending, is judged by the absence of any outcome and an unchanged lookup payload.

// File: rtl/vix_pkg.sv
package vix_pkg;
  localparam int TYPE_W  = 32;
  localparam int PARAM_W = 64;
  localparam int NMASK_W = 16;
  localparam int EXC_W   = 32;
  localparam int GEN_W   = 64;

  typedef enum logic {ST_IDLE, ST_WAIT} vix_state_t;
endpackage

// File: rtl/vix_decode.sv
module vix_decode
  import vix_pkg::*;
#(
  parameter logic [31:0] CR_RD_BASE = 32'd0,
  parameter logic [31:0] CR_WR_BASE = 32'd16,
  parameter logic [31:0] DR_RD_BASE = 32'd32,
  parameter logic [31:0] DR_WR_BASE = 32'd48,
  parameter logic [31:0] EXC_BASE   = 32'd64,
  parameter logic [31:0] GEN_BASE   = 32'd96,
  parameter logic [31:0] MSR_CODE   = 32'd124,
  parameter logic [31:0] IO_CODE    = 32'd123
) (
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [NMASK_W-1:0] cr_rd_i,
  input  logic [NMASK_W-1:0] cr_wr_i,
  input  logic [NMASK_W-1:0] dr_rd_i,
  input  logic [NMASK_W-1:0] dr_wr_i,
  input  logic [EXC_W-1:0]   exc_i,
  input  logic [GEN_W-1:0]   gen_i,
  output logic               sel_bit_o,
  output logic               lookup_o,
  output logic               lookup_io_o
);
  localparam logic [31:0] CR_N  = 32'd9;
  localparam logic [31:0] DR_N  = 32'd8;
  localparam logic [31:0] EXC_N = EXC_W;
  localparam logic [31:0] GEN_N = GEN_W;

  function automatic logic in_rng(logic [31:0] t, logic [31:0] b, logic [31:0] n);
    return (t >= b) && ((t - b) < n);
  endfunction

  logic [31:0] d_cr_rd, d_cr_wr, d_dr_rd, d_dr_wr, d_exc, d_gen;

  always_comb begin
    d_cr_rd = type_i - CR_RD_BASE;
    d_cr_wr = type_i - CR_WR_BASE;
    d_dr_rd = type_i - DR_RD_BASE;
    d_dr_wr = type_i - DR_WR_BASE;
    d_exc   = type_i - EXC_BASE;
    d_gen   = type_i - GEN_BASE;
    sel_bit_o = 1'b0;
    if (in_rng(type_i, CR_RD_BASE, CR_N))      sel_bit_o = cr_rd_i[d_cr_rd[3:0]];
    else if (in_rng(type_i, CR_WR_BASE, CR_N)) sel_bit_o = cr_wr_i[d_cr_wr[3:0]];
    else if (in_rng(type_i, DR_RD_BASE, DR_N)) sel_bit_o = dr_rd_i[d_dr_rd[3:0]];
    else if (in_rng(type_i, DR_WR_BASE, DR_N)) sel_bit_o = dr_wr_i[d_dr_wr[3:0]];
    else if (in_rng(type_i, EXC_BASE, EXC_N))  sel_bit_o = exc_i[d_exc[4:0]];
    else if (in_rng(type_i, GEN_BASE, GEN_N))  sel_bit_o = gen_i[d_gen[5:0]];
    lookup_io_o = (type_i == IO_CODE);
    lookup_o    = (type_i == MSR_CODE) || lookup_io_o;
  end
endmodule

// File: rtl/vix_bitmaps.sv
module vix_bitmaps
  import vix_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_i,
  input  logic               clr_i,
  input  logic [NMASK_W-1:0] cr_rd_d,
  input  logic [NMASK_W-1:0] cr_wr_d,
  input  logic [NMASK_W-1:0] dr_rd_d,
  input  logic [NMASK_W-1:0] dr_wr_d,
  input  logic [EXC_W-1:0]   exc_d,
  input  logic [GEN_W-1:0]   gen_d,
  output logic               en_o,
  output logic [NMASK_W-1:0] cr_rd_q,
  output logic [NMASK_W-1:0] cr_wr_q,
  output logic [NMASK_W-1:0] dr_rd_q,
  output logic [NMASK_W-1:0] dr_wr_q,
  output logic [EXC_W-1:0]   exc_q,
  output logic [GEN_W-1:0]   gen_q
);
  logic upd;
  logic en_n;
  logic [NMASK_W-1:0] cr_rd_n, cr_wr_n, dr_rd_n, dr_wr_n;
  logic [EXC_W-1:0]   exc_n;
  logic [GEN_W-1:0]   gen_n;

  // Arm has priority over the clear an exit requests.
  always_comb begin
    upd     = arm_i | clr_i;
    en_n    = arm_i;
    cr_rd_n = arm_i ? cr_rd_d : '0;
    cr_wr_n = arm_i ? cr_wr_d : '0;
    dr_rd_n = arm_i ? dr_rd_d : '0;
    dr_wr_n = arm_i ? dr_wr_d : '0;
    exc_n   = arm_i ? exc_d   : '0;
    gen_n   = arm_i ? gen_d   : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= 1'b0;
      cr_rd_q <= '0;
      cr_wr_q <= '0;
      dr_rd_q <= '0;
      dr_wr_q <= '0;
      exc_q   <= '0;
      gen_q   <= '0;
    end else if (upd) begin
      en_o    <= en_n;
      cr_rd_q <= cr_rd_n;
      cr_wr_q <= cr_wr_n;
      dr_rd_q <= dr_rd_n;
      dr_wr_q <= dr_wr_n;
      exc_q   <= exc_n;
      gen_q   <= gen_n;
    end
  end

  a_r11_arm_enables: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> en_o);
  a_r10_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !arm_i) |=> (!en_o && gen_q == '0 && exc_q == '0 && cr_rd_q == '0));
endmodule

// File: rtl/vix_ctrl.sv
module vix_ctrl
  import vix_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid_i,
  input  logic [TYPE_W-1:0]  ev_type_i,
  input  logic [PARAM_W-1:0] ev_param_i,
  input  logic               en_i,
  input  logic               sel_bit_i,
  input  logic               lookup_i,
  input  logic               lookup_io_i,
  input  logic               lk_rsp_i,
  input  logic               lk_hit_i,
  output logic               clr_o,
  output logic               busy_o,
  output logic               lk_io_o,
  output logic               exit_valid_o,
  output logic               done_o,
  output logic [TYPE_W-1:0]  type_q,
  output logic [PARAM_W-1:0] param_q
);
  vix_state_t st_q, st_d;
  logic accept, exit_d, done_d, io_d;

  always_comb begin
    accept = ev_valid_i && (st_q == ST_IDLE);
    st_d   = st_q;
    exit_d = 1'b0;
    done_d = 1'b0;
    io_d   = lk_io_o;
    if (accept) begin
      if (!en_i)          done_d = 1'b1;
      else if (lookup_i) begin
        if (sel_bit_i) begin
          st_d = ST_WAIT;
          io_d = lookup_io_i;
        end else          done_d = 1'b1;
      end
      else if (sel_bit_i) exit_d = 1'b1;
      else                done_d = 1'b1;
    end else if (st_q == ST_WAIT && lk_rsp_i) begin
      st_d = ST_IDLE;
      if (lk_hit_i) exit_d = 1'b1;
      else          done_d = 1'b1;
    end
    clr_o = exit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      exit_valid_o <= 1'b0;
      done_o       <= 1'b0;
      lk_io_o      <= 1'b0;
    end else begin
      st_q         <= st_d;
      exit_valid_o <= exit_d;
      done_o       <= done_d;
      lk_io_o      <= io_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= '0;
      param_q <= '0;
    end else if (accept) begin
      type_q  <= ev_type_i;
      param_q <= ev_param_i;
    end
  end

  assign busy_o = (st_q == ST_WAIT);

  a_r1_off_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !en_i) |=> (done_o && !exit_valid_o));
  a_r8_hit_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && lk_rsp_i && lk_hit_i) |=> exit_valid_o);
  a_r12_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !lk_rsp_i) |=> (busy_o && $stable(type_q) && $stable(param_q)));
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid_o |-> !done_o);
endmodule

// File: rtl/vix_intercept_top.sv
module vix_intercept_top
  import vix_pkg::*;
#(
  parameter logic [31:0] CR_RD_BASE = 32'd0,
  parameter logic [31:0] CR_WR_BASE = 32'd16,
  parameter logic [31:0] DR_RD_BASE = 32'd32,
  parameter logic [31:0] DR_WR_BASE = 32'd48,
  parameter logic [31:0] EXC_BASE   = 32'd64,
  parameter logic [31:0] GEN_BASE   = 32'd96,
  parameter logic [31:0] MSR_CODE   = 32'd124,
  parameter logic [31:0] IO_CODE    = 32'd123
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_i,
  input  logic [NMASK_W-1:0] cr_rd_mask_i,
  input  logic [NMASK_W-1:0] cr_wr_mask_i,
  input  logic [NMASK_W-1:0] dr_rd_mask_i,
  input  logic [NMASK_W-1:0] dr_wr_mask_i,
  input  logic [EXC_W-1:0]   exc_mask_i,
  input  logic [GEN_W-1:0]   gen_mask_i,
  output logic               en_o,
  input  logic               ev_valid_i,
  input  logic [TYPE_W-1:0]  ev_type_i,
  input  logic [PARAM_W-1:0] ev_param_i,
  output logic               busy_o,
  output logic               lk_req_o,
  output logic               lk_io_o,
  output logic [TYPE_W-1:0]  lk_type_o,
  output logic [PARAM_W-1:0] lk_param_o,
  input  logic               lk_rsp_i,
  input  logic               lk_hit_i,
  output logic               exit_valid_o,
  output logic [TYPE_W-1:0]  exit_type_o,
  output logic [PARAM_W-1:0] exit_param_o,
  output logic               done_o
);
  // Reset asserts asynchronously, releases on the clock.
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic [NMASK_W-1:0] cr_rd_q, cr_wr_q, dr_rd_q, dr_wr_q;
  logic [EXC_W-1:0]   exc_q;
  logic [GEN_W-1:0]   gen_q;
  logic sel_bit, lookup, lookup_io, clr;
  logic [TYPE_W-1:0]  type_q;
  logic [PARAM_W-1:0] param_q;

  vix_bitmaps u_maps (
    .clk(clk), .rst_n(srst_n), .arm_i(arm_i), .clr_i(clr),
    .cr_rd_d(cr_rd_mask_i), .cr_wr_d(cr_wr_mask_i),
    .dr_rd_d(dr_rd_mask_i), .dr_wr_d(dr_wr_mask_i),
    .exc_d(exc_mask_i), .gen_d(gen_mask_i), .en_o(en_o),
    .cr_rd_q(cr_rd_q), .cr_wr_q(cr_wr_q), .dr_rd_q(dr_rd_q),
    .dr_wr_q(dr_wr_q), .exc_q(exc_q), .gen_q(gen_q)
  );

  vix_decode #(
    .CR_RD_BASE(CR_RD_BASE), .CR_WR_BASE(CR_WR_BASE),
    .DR_RD_BASE(DR_RD_BASE), .DR_WR_BASE(DR_WR_BASE),
    .EXC_BASE(EXC_BASE), .GEN_BASE(GEN_BASE),
    .MSR_CODE(MSR_CODE), .IO_CODE(IO_CODE)
  ) u_dec (
    .type_i(ev_type_i), .cr_rd_i(cr_rd_q), .cr_wr_i(cr_wr_q),
    .dr_rd_i(dr_rd_q), .dr_wr_i(dr_wr_q), .exc_i(exc_q), .gen_i(gen_q),
    .sel_bit_o(sel_bit), .lookup_o(lookup), .lookup_io_o(lookup_io)
  );

  vix_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .ev_valid_i(ev_valid_i),
    .ev_type_i(ev_type_i), .ev_param_i(ev_param_i), .en_i(en_o),
    .sel_bit_i(sel_bit), .lookup_i(lookup), .lookup_io_i(lookup_io),
    .lk_rsp_i(lk_rsp_i), .lk_hit_i(lk_hit_i), .clr_o(clr),
    .busy_o(busy_o), .lk_io_o(lk_io_o), .exit_valid_o(exit_valid_o),
    .done_o(done_o), .type_q(type_q), .param_q(param_q)
  );

  assign lk_req_o     = busy_o;
  assign lk_type_o    = type_q;
  assign lk_param_o   = param_q;
  assign exit_type_o  = type_q;
  assign exit_param_o = param_q;
endmodule

// File: tb/sim_vix_intercept_top.sv
module sim_vix_intercept_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0;
  logic [15:0] cr_rd_mask_i = '0, cr_wr_mask_i = '0, dr_rd_mask_i = '0, dr_wr_mask_i = '0;
  logic [31:0] exc_mask_i = '0;
  logic [63:0] gen_mask_i = '0;
  logic        ev_valid_i = 1'b0;
  logic [31:0] ev_type_i = '0;
  logic [63:0] ev_param_i = '0;
  logic        lk_rsp_i = 1'b0, lk_hit_i = 1'b0;
  logic en_o, busy_o, lk_req_o, lk_io_o, exit_valid_o, done_o;
  logic [31:0] lk_type_o, exit_type_o;
  logic [63:0] lk_param_o, exit_param_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vix_intercept_top u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
    .cr_rd_mask_i(cr_rd_mask_i), .cr_wr_mask_i(cr_wr_mask_i),
    .dr_rd_mask_i(dr_rd_mask_i), .dr_wr_mask_i(dr_wr_mask_i),
    .exc_mask_i(exc_mask_i), .gen_mask_i(gen_mask_i), .en_o(en_o),
    .ev_valid_i(ev_valid_i), .ev_type_i(ev_type_i), .ev_param_i(ev_param_i),
    .busy_o(busy_o), .lk_req_o(lk_req_o), .lk_io_o(lk_io_o),
    .lk_type_o(lk_type_o), .lk_param_o(lk_param_o),
    .lk_rsp_i(lk_rsp_i), .lk_hit_i(lk_hit_i),
    .exit_valid_o(exit_valid_o), .exit_type_o(exit_type_o),
    .exit_param_o(exit_param_o), .done_o(done_o)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_masks(logic [15:0] crr, logic [15:0] crw, logic [15:0] drr,
                            logic [15:0] drw, logic [31:0] exc, logic [63:0] gen);
    cr_rd_mask_i = crr; cr_wr_mask_i = crw; dr_rd_mask_i = drr;
    dr_wr_mask_i = drw; exc_mask_i = exc; gen_mask_i = gen;
  endtask

  task automatic arm(logic [15:0] crr, logic [15:0] crw, logic [15:0] drr,
                     logic [15:0] drw, logic [31:0] exc, logic [63:0] gen);
    @(negedge clk);
    load_masks(crr, crw, drr, drw, exc, gen);
    arm_i = 1'b1;
    @(posedge clk); #1;
    arm_i = 1'b0;
  endtask

  task automatic send(logic [31:0] t, logic [63:0] p);
    @(negedge clk);
    ev_valid_i = 1'b1; ev_type_i = t; ev_param_i = p;
    @(posedge clk); #1;
    ev_valid_i = 1'b0;
  endtask

  task automatic respond(logic hit);
    @(negedge clk);
    lk_rsp_i = 1'b1; lk_hit_i = hit;
    @(posedge clk); #1;
    lk_rsp_i = 1'b0;
  endtask

  task automatic expect_outcome(string tag, logic ex, logic dn);
    check({tag, " exit"}, {63'b0, exit_valid_o}, {63'b0, ex});
    check({tag, " done"}, {63'b0, done_o}, {63'b0, dn});
  endtask

  task automatic t_reset();
    check("R14 en", {63'b0, en_o}, 64'd0);
    check("R14 busy", {63'b0, busy_o}, 64'd0);
    check("R14 lkreq", {63'b0, lk_req_o}, 64'd0);
    expect_outcome("R14", 1'b0, 1'b0);
  endtask

  task automatic t_disabled();
    send(32'd2, 64'h11);
    expect_outcome("R1 disabled", 1'b0, 1'b1);
    send(32'd130, 64'h12);
    expect_outcome("R1 disabled gen", 1'b0, 1'b1);
  endtask

  task automatic t_cr_read();
    arm(16'h0104, 16'h0, 16'h0, 16'h0, 32'h0, 64'h0);
    check("R11 armed", {63'b0, en_o}, 64'd1);
    send(32'd3, 64'h21);
    expect_outcome("R2 clear bit", 1'b0, 1'b1);
    send(32'd8, 64'hDEAD_BEEF_0000_0008);
    expect_outcome("R2 top code", 1'b1, 1'b0);
    check("R9 type", {32'b0, exit_type_o}, 64'd8);
    check("R9 param", exit_param_o, 64'hDEAD_BEEF_0000_0008);
    check("R10 en cleared", {63'b0, en_o}, 64'd0);
    @(posedge clk); #1;
    check("R9 one cycle", {63'b0, exit_valid_o}, 64'd0);
    send(32'd8, 64'h22);
    expect_outcome("R10 repeat", 1'b0, 1'b1);
    arm(16'hFFFF, 16'h0, 16'h0, 16'h0, 32'h0, {64{1'b1}});
    send(32'd9, 64'h23);
    expect_outcome("R2 code base+9", 1'b0, 1'b1);
  endtask

  task automatic t_cr_write();
    arm(16'h0, 16'h0001, 16'h0, 16'h0, 32'h0, 64'h0);
    send(32'd16, 64'h31);
    expect_outcome("R3 bit0", 1'b1, 1'b0);
    check("R3 type", {32'b0, exit_type_o}, 64'd16);
  endtask

  task automatic t_dr();
    arm(16'h0, 16'h0, 16'h0080, 16'hFFFF, 32'h0, 64'h0);
    send(32'd56, 64'h41);
    expect_outcome("R4 dr write off8", 1'b0, 1'b1);
    send(32'd39, 64'h42);
    expect_outcome("R4 dr read bit7", 1'b1, 1'b0);
  endtask

  task automatic t_exc();
    arm(16'h0, 16'h0, 16'h0, 16'h0, 32'h8000_0000, 64'h0);
    send(32'd78, 64'h51);
    expect_outcome("R5 bit14 clear", 1'b0, 1'b1);
    send(32'd95, 64'h52);
    expect_outcome("R5 bit31", 1'b1, 1'b0);
  endtask

  task automatic t_gen();
    arm(16'h0, 16'h0, 16'h0, 16'h0, 32'h0, {64{1'b1}});
    send(32'd160, 64'h61);
    expect_outcome("R6 beyond range", 1'b0, 1'b1);
    send(32'd159, 64'h62);
    expect_outcome("R6 bit63", 1'b1, 1'b0);
  endtask

  task automatic t_lookup();
    arm(16'hFFFF, 16'h0, 16'h0, 16'h0, 32'h0, 64'h0);
    send(32'd124, 64'h71);
    expect_outcome("R7 gen bit clear", 1'b0, 1'b1);
    check("R7 no request", {63'b0, lk_req_o}, 64'd0);
    arm(16'hFFFF, 16'h0, 16'h0, 16'h0, 32'h0, 64'h1 << 28);
    send(32'd124, 64'h72);
    expect_outcome("R7 msr wait", 1'b0, 1'b0);
    check("R7 request", {63'b0, lk_req_o}, 64'd1);
    check("R7 busy", {63'b0, busy_o}, 64'd1);
    check("R7 msr kind", {63'b0, lk_io_o}, 64'd0);
    send(32'd1, 64'h99);
    expect_outcome("R12 ignored", 1'b0, 1'b0);
    check("R12 payload", lk_param_o, 64'h72);
    check("R12 type", {32'b0, lk_type_o}, 64'd124);
    respond(1'b0);
    expect_outcome("R8 miss", 1'b0, 1'b1);
    check("R8 still enabled", {63'b0, en_o}, 64'd1);
    arm(16'h0, 16'h0, 16'h0, 16'h0, 32'h0, 64'h1 << 27);
    send(32'd123, 64'h0000_0010_0000_0073);
    check("R7 io kind", {63'b0, lk_io_o}, 64'd1);
    respond(1'b1);
    expect_outcome("R8 hit", 1'b1, 1'b0);
    check("R8 type", {32'b0, exit_type_o}, 64'd123);
    check("R8 param", exit_param_o, 64'h0000_0010_0000_0073);
  endtask

  task automatic t_overlap();
    arm(16'h0, 16'h0, 16'h0, 16'h0, 32'h1, 64'h0);
    @(negedge clk);
    load_masks(16'h0020, 16'h0, 16'h0, 16'h0, 32'h0, 64'h0);
    arm_i = 1'b1;
    ev_valid_i = 1'b1; ev_type_i = 32'd64; ev_param_i = 64'h81;
    @(posedge clk); #1;
    arm_i = 1'b0; ev_valid_i = 1'b0;
    expect_outcome("R13 old masks", 1'b1, 1'b0);
    check("R13 enable kept", {63'b0, en_o}, 64'd1);
    send(32'd5, 64'h82);
    expect_outcome("R13 new masks", 1'b1, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_disabled();
    t_cr_read();
    t_cr_write();
    t_dr();
    t_exc();
    t_gen();
    t_lookup();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule